// File: doc/BRIEF.md
# Error-Tagged Serial Receiver

This block receives asynchronous serial characters on a single line and keeps them for software in a small holding buffer. It oversamples the line at sixteen times the bit rate; the oversampling tick comes from a baud generator outside the block. Frame configuration inputs select how many data bits a character has, whether a parity bit follows the data (and which sense it has), and whether the sender uses one or two stop bits.

Every character that completes a frame is stored with two error tags of its own: a parity error bit and a framing error bit. Software reads one 16-bit word that combines the oldest stored character with its tags, and a read strobe removes that entry. A stored-data status bit, a sticky data interrupt flag and a sticky overflow interrupt flag report the state of the buffer. The receiver is switched on and off by one-cycle command pulses.

Top module: `uart_rx_tagged`

## Requirements
- R1: `cfg_len_i` holds the character length minus three (code 2 = 5 bits, 5 = 8 bits, 6 = 9 bits). Data bits arrive least significant first and appear in `rd_word_o[8:0]`, with unused high data bits at zero.
- R2: `cfg_par_i` selects the parity: 2'b00 none, 2'b10 even, 2'b11 odd. Code 2'b01 is treated as no parity.
- R3: In `rd_word_o`, bit 14 is the parity error of that character and bit 15 its framing error, which is set when the stop bit is sampled low. Bits 13:9 always read zero, and the whole word is zero while the buffer is empty.
- R4: With `cfg_stop2_i` high, only the first stop bit is checked. A low second stop bit produces no error, and the next frame is still received.
- R5: A line held low for a whole frame yields a stored word with the framing error set and all data bits zero.
- R6: `cmd_en_i` switches the receiver on and `cmd_dis_i` switches it off; a low command input has no effect, and when both are high in one cycle the disable wins. While the receiver is off, line activity stores nothing.
- R7: The buffer holds two characters and returns them oldest first. A `rd_i` pulse removes the oldest entry.
- R8: `avail_o` is high while at least one character is unread. `dv_flag_o` sets whenever a character is stored and stays set until `irq_clr_i[0]` is pulsed.
- R9: A character that completes while both entries are full is discarded and the stored entries are kept. `ovf_flag_o` sets and stays set until `irq_clr_i[1]` is pulsed.
- R10: A start bit is accepted only if the line is still low at the middle of the bit, so a low pulse shorter than half a bit stores nothing.
- R11: Disabling the receiver abandons any frame in progress; characters already stored stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, sixteen per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_len_i | input | 4 | Character length minus three |
| cfg_par_i | input | 2 | Parity mode |
| cfg_stop2_i | input | 1 | Sender uses two stop bits |
| cmd_en_i | input | 1 | Enable command pulse |
| cmd_dis_i | input | 1 | Disable command pulse |
| rd_i | input | 1 | Read strobe; removes the oldest entry |
| irq_clr_i | input | 2 | Flag clear: bit 0 data flag, bit 1 overflow flag |
| rd_word_o | output | 16 | Oldest character with its error tags |
| avail_o | output | 1 | At least one character unread |
| dv_flag_o | output | 1 | Sticky data interrupt flag |
| ovf_flag_o | output | 1 | Sticky overflow interrupt flag |

## Verification
The bench targets a break frame: a design that stops as soon as it sees a zero character, or that re-triggers on the long low level, would store nothing or store several words instead of one framing-tagged zero. A third unread character must be dropped. A design that overwrites the oldest entry or advances the write pointer on overflow would return the wrong pair in the wrong order. A low second stop bit must pass without error, a short glitch must be rejected at mid-bit, and a frame cut off by a disable must leave no partial character behind while the earlier entry stays readable. Each of these would show up as an extra, missing or mistagged word in the scoreboard.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W   = 9;
    localparam int WORD_W   = 16;
    localparam int PERR_POS = 14;
    localparam int FERR_POS = 15;
    localparam int PAD_W    = PERR_POS - DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       rxd_i,
    input  logic       en_i,
    input  logic [3:0] len_i,
    input  logic [1:0] par_i,
    input  logic       stop2_i,
    output logic       push_o,
    output rx_char_t   char_o
);

    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_state_e              st;
        logic [CW-1:0]          cnt;
        logic [3:0]             idx;
        logic [DATA_W-1:0]      data;
        logic                   acc;
        logic                   perr;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } frm_t;

    frm_t q, d;
    logic       rx_s;
    logic [4:0] len_ext;
    logic [3:0] nbits;

    assign rx_s    = q.sync[SYNC_STAGES-1];
    assign len_ext = {1'b0, len_i} + 5'd3;
    assign nbits   = (len_ext > 5'(DATA_W)) ? 4'(DATA_W) : len_ext[3:0];

    always_comb begin
        d      = q;
        push_o = 1'b0;
        d.sync = {q.sync[SYNC_STAGES-2:0], rxd_i};
        d.prev = rx_s;
        case (q.st)
            ST_IDLE: begin
                if (q.prev && !rx_s) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (q.cnt == MID) begin
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.data = '0;
                        d.acc  = 1'b0;
                        d.perr = 1'b0;
                        d.st   = rx_s ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        d.cnt          = '0;
                        d.data[q.idx]  = rx_s;
                        d.acc          = q.acc ^ rx_s;
                        if (q.idx == nbits - 4'd1) begin
                            d.st = par_i[1] ? ST_PAR : ST_STOP;
                        end else begin
                            d.idx = q.idx + 4'd1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        d.cnt  = '0;
                        d.perr = q.acc ^ rx_s ^ par_i[0];
                        d.st   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        d.cnt  = '0;
                        push_o = 1'b1;
                        d.st   = stop2_i ? ST_STOP2 : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP2: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!en_i) begin
            d.st   = ST_IDLE;
            push_o = 1'b0;
        end
    end

    assign char_o = '{ferr: !rx_s, perr: q.perr, data: q.data};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.sync <= '1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     push_i,
    input  rx_char_t char_i,
    input  logic     pop_i,
    output rx_char_t head_o,
    output logic     avail_o,
    output logic     store_o,
    output logic     ovf_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [PW-1:0]        wp;
        logic [PW-1:0]        rp;
        logic [PW:0]          cnt;
    } hold_t;

    hold_t q, d;
    logic  pop_ok, space;

    always_comb begin
        d       = q;
        pop_ok  = pop_i && (q.cnt != '0);
        space   = (q.cnt < (PW+1)'(DEPTH)) || pop_ok;
        store_o = push_i && space;
        ovf_o   = push_i && !space;
        if (store_o) begin
            d.mem[q.wp] = char_i;
            d.wp        = (q.wp == LAST_IDX) ? '0 : q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = (q.rp == LAST_IDX) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + (PW+1)'(store_o) - (PW+1)'(pop_ok);
    end

    assign head_o  = q.mem[q.rp];
    assign avail_o = (q.cnt != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH       = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic [3:0]        cfg_len_i,
    input  logic [1:0]        cfg_par_i,
    input  logic              cfg_stop2_i,
    input  logic              cmd_en_i,
    input  logic              cmd_dis_i,
    input  logic              rd_i,
    input  logic [1:0]        irq_clr_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              avail_o,
    output logic              dv_flag_o,
    output logic              ovf_flag_o
);

    typedef struct packed {
        logic en;
        logic dv;
        logic ovf;
    } ctl_t;

    ctl_t     q, d;
    logic     push, store, ovf;
    rx_char_t rx_char, head;

    uart_rx_frame #(
        .OVERSAMPLE (OVERSAMPLE),
        .SYNC_STAGES(SYNC_STAGES)
    ) i_frame (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .rxd_i  (rxd_i),
        .en_i   (q.en),
        .len_i  (cfg_len_i),
        .par_i  (cfg_par_i),
        .stop2_i(cfg_stop2_i),
        .push_o (push),
        .char_o (rx_char)
    );

    uart_rx_hold #(
        .DEPTH(DEPTH)
    ) i_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (push),
        .char_i (rx_char),
        .pop_i  (rd_i),
        .head_o (head),
        .avail_o(avail_o),
        .store_o(store),
        .ovf_o  (ovf)
    );

    always_comb begin
        d = q;
        if (cmd_dis_i) begin
            d.en = 1'b0;
        end else if (cmd_en_i) begin
            d.en = 1'b1;
        end
        if (irq_clr_i[0]) d.dv = 1'b0;
        if (store)        d.dv = 1'b1;
        if (irq_clr_i[1]) d.ovf = 1'b0;
        if (ovf)          d.ovf = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_word_o  = avail_o ? {head.ferr, head.perr, {PAD_W{1'b0}}, head.data}
                                : '0;
    assign dv_flag_o  = q.dv;
    assign ovf_flag_o = q.ovf;

endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [15:0] rd_word_o,
    input logic        avail_o,
    input logic        dv_flag_o,
    input logic        ovf_flag_o,
    input logic [1:0]  irq_clr_i
);

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !avail_o |-> (rd_word_o == 16'h0000)); // R3

    AST_PAD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_word_o[13:9] == 5'b0); // R3

    AST_DV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dv_flag_o && !irq_clr_i[0]) |=> dv_flag_o); // R8

    AST_AVAIL_SETS_DV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(avail_o) |-> dv_flag_o); // R8

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_flag_o && !irq_clr_i[1]) |=> ovf_flag_o); // R9

endmodule

bind uart_rx_tagged uart_rx_tagged_chk i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_word_o (rd_word_o),
    .avail_o   (avail_o),
    .dv_flag_o (dv_flag_o),
    .ovf_flag_o(ovf_flag_o),
    .irq_clr_i (irq_clr_i)
);

// File: tb/test_uart_rx_tagged.sv
module test_uart_rx_tagged;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        rxd = 1'b1;
    logic [3:0]  cfg_len = 4'd5;
    logic [1:0]  cfg_par = 2'b00;
    logic        cfg_stop2 = 1'b0;
    logic        cmd_en = 1'b0;
    logic        cmd_dis = 1'b0;
    logic        rd = 1'b0;
    logic [1:0]  irq_clr = 2'b00;
    logic [15:0] rd_word;
    logic        avail, dv_flag, ovf_flag;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   auto_rd = 1'b0;
    bit   done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    uart_rx_tagged i_uart_rx_tagged (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .rxd_i      (rxd),
        .cfg_len_i  (cfg_len),
        .cfg_par_i  (cfg_par),
        .cfg_stop2_i(cfg_stop2),
        .cmd_en_i   (cmd_en),
        .cmd_dis_i  (cmd_dis),
        .rd_i       (rd),
        .irq_clr_i  (irq_clr),
        .rd_word_o  (rd_word),
        .avail_o    (avail),
        .dv_flag_o  (dv_flag),
        .ovf_flag_o (ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // tick generator
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c    = (c == TICK_DIV - 1) ? 0 : c + 1;
            tick = (c == 0);
        end
    end

    // monitor: pops the buffer and compares against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            rd = 1'b0;
            if (auto_rd && avail) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected word", {16'h0, rd_word}, 32'hFFFF_FFFF);
                end else begin
                    chk(tag_q.pop_front(), {16'h0, rd_word}, {16'h0, exp_q.pop_front()});
                end
                rd = 1'b1;
            end
        end
    end

    task automatic expect_word(input string tag, input logic [8:0] dat, input int nb,
                               input bit pe, input bit fe);
        logic [8:0] m;
        m = 9'((1 << nb) - 1);
        exp_q.push_back({fe, pe, 5'b0, dat & m});
        tag_q.push_back(tag);
    endtask

    task automatic line(input logic b, input int nbit);
        rxd = b;
        repeat (nbit * BIT_CLK) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] dat, input int nb, input logic [1:0] pm,
                        input bit two_stop, input bit bad_par, input bit low_stop,
                        input bit low_stop2);
        logic p;
        line(1'b0, 1);
        for (int i = 0; i < nb; i++) line(dat[i], 1);
        if (pm[1]) begin
            p = 1'b0;
            for (int i = 0; i < nb; i++) p ^= dat[i];
            p = p ^ pm[0] ^ bad_par;
            line(p, 1);
        end
        line(!low_stop, 1);
        if (two_stop) line(!low_stop2, 1);
        line(1'b1, 2);
    endtask

    task automatic pulse_cmd(input bit en, input bit dis);
        cmd_en  = en;
        cmd_dis = dis;
        @(negedge clk);
        cmd_en  = 1'b0;
        cmd_dis = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (20) @(negedge clk);
        chk(tag, exp_q.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset word", {16'h0, rd_word}, 32'h0);
        chk("R8 reset avail", {31'h0, avail}, 32'h0);
        chk("R8 reset dv flag", {31'h0, dv_flag}, 32'h0);
        chk("R9 reset ovf flag", {31'h0, ovf_flag}, 32'h0);

        // R6: receiver off after reset, line activity ignored
        send(9'h0A5, 8, 2'b00, 0, 0, 0, 0);
        chk("R6 off ignores line", {31'h0, avail}, 32'h0);
        // R6: both commands at once, disable wins
        pulse_cmd(1, 1);
        send(9'h0A5, 8, 2'b00, 0, 0, 0, 0);
        chk("R6 disable wins", {31'h0, avail}, 32'h0);

        pulse_cmd(1, 0);
        auto_rd = 1'b1;

        // R1: 8-bit characters, LSB first
        expect_word("R1 8N1 a5", 9'h0A5, 8, 0, 0); send(9'h0A5, 8, 2'b00, 0, 0, 0, 0);
        expect_word("R1 8N1 3c", 9'h03C, 8, 0, 0); send(9'h03C, 8, 2'b00, 0, 0, 0, 0);
        // R1: 5-bit characters
        cfg_len = 4'd2;
        expect_word("R1 5-bit 15", 9'h015, 5, 0, 0); send(9'h015, 5, 2'b00, 0, 0, 0, 0);
        // R1: 9-bit characters
        cfg_len = 4'd6;
        expect_word("R1 9-bit 1c3", 9'h1C3, 9, 0, 0); send(9'h1C3, 9, 2'b00, 0, 0, 0, 0);
        drain("R1 all words seen");

        // R2/R3: 7-bit even parity, good then bad
        cfg_len = 4'd4; cfg_par = 2'b10;
        expect_word("R2 even good", 9'h05B, 7, 0, 0); send(9'h05B, 7, 2'b10, 0, 0, 0, 0);
        expect_word("R3 even bad perr", 9'h05B, 7, 1, 0); send(9'h05B, 7, 2'b10, 0, 1, 0, 0);
        // odd parity
        cfg_par = 2'b11;
        expect_word("R2 odd good", 9'h021, 7, 0, 0); send(9'h021, 7, 2'b11, 0, 0, 0, 0);
        expect_word("R3 odd bad perr", 9'h021, 7, 1, 0); send(9'h021, 7, 2'b11, 0, 1, 0, 0);
        // reserved code 01 acts as no parity
        cfg_len = 4'd5; cfg_par = 2'b01;
        expect_word("R2 code 01 no parity", 9'h0C7, 8, 0, 0); send(9'h0C7, 8, 2'b00, 0, 0, 0, 0);
        cfg_par = 2'b00;
        // R3: low stop bit gives framing error
        expect_word("R3 low stop ferr", 9'h066, 8, 0, 1); send(9'h066, 8, 2'b00, 0, 0, 1, 0);
        // R5: break
        expect_word("R5 break", 9'h000, 8, 0, 1); line(1'b0, 10); line(1'b1, 3);
        drain("R5 one word per break");

        // R4: two stop bits, second one low
        cfg_stop2 = 1'b1;
        expect_word("R4 second stop ignored", 9'h09E, 8, 0, 0); send(9'h09E, 8, 2'b00, 1, 0, 0, 1);
        expect_word("R4 next frame", 9'h011, 8, 0, 0); send(9'h011, 8, 2'b00, 1, 0, 0, 0);
        cfg_stop2 = 1'b0;
        drain("R4 words seen");

        // R10: short glitch rejected
        line(1'b0, 0); repeat (12) @(negedge clk); line(1'b1, 3);
        drain("R10 glitch");
        chk("R10 glitch stores nothing", {31'h0, avail}, 32'h0);

        // R8: flag clear
        irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00;
        chk("R8 dv flag cleared", {31'h0, dv_flag}, 32'h0);

        // R9: overflow keeps first two entries
        auto_rd = 1'b0;
        send(9'h011, 8, 2'b00, 0, 0, 0, 0);
        chk("R8 avail after store", {31'h0, avail}, 32'h1);
        chk("R8 dv flag set", {31'h0, dv_flag}, 32'h1);
        send(9'h022, 8, 2'b00, 0, 0, 0, 0);
        chk("R9 no ovf at two", {31'h0, ovf_flag}, 32'h0);
        send(9'h033, 8, 2'b00, 0, 0, 0, 0);
        chk("R9 ovf flag set", {31'h0, ovf_flag}, 32'h1);
        expect_word("R7 first kept", 9'h011, 8, 0, 0);
        expect_word("R7 second kept", 9'h022, 8, 0, 0);
        auto_rd = 1'b1;
        drain("R9 third discarded");
        chk("R8 avail after drain", {31'h0, avail}, 32'h0);
        chk("R9 ovf flag sticky", {31'h0, ovf_flag}, 32'h1);
        irq_clr = 2'b10; @(negedge clk); irq_clr = 2'b00;
        chk("R9 ovf flag cleared", {31'h0, ovf_flag}, 32'h0);

        // R11: disable mid-frame
        auto_rd = 1'b0;
        send(9'h05A, 8, 2'b00, 0, 0, 0, 0);
        line(1'b0, 1); line(1'b1, 1); line(1'b0, 1);
        pulse_cmd(0, 1);
        line(1'b1, 3);
        chk("R11 stored data kept", {16'h0, rd_word}, 32'h005A);
        pulse_cmd(1, 0);
        send(9'h03C, 8, 2'b00, 0, 0, 0, 0);
        expect_word("R11 entry before disable", 9'h05A, 8, 0, 0);
        expect_word("R11 frame after enable", 9'h03C, 8, 0, 0);
        auto_rd = 1'b1;
        drain("R11 no partial word");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule